// File: doc/BRIEF.md
# Host Register Instruction Sequencer

This block takes 64-bit register instructions from a host-to-device instruction stream and splits each word into fields: a read flag, a commit-notification request, a subsystem identifier, a register address and a write value. It offers the decoded instruction to the downstream subsystems through a valid/ready handshake. It keeps exactly one instruction in flight and fetches the next word only after the current one has fully completed.

A write completes when the downstream side accepts it. If the write asked for a commit notification, it first runs a four-phase go/received exchange with the host on a dedicated notify pair. A read completes when a subsystem reports the result on the completion input. The block captures that value and hands it to the host through a four-phase go/received exchange on the read-return pair. A synchronous control input forces the sequencer back to its idle, ready-for-instruction state and holds it there for as long as it stays high.

Top module: `regseq_top`

## Requirements
- R1: Each popped word is decoded as follows, and the fields are presented unchanged on the downstream outputs: bit 63 is the read flag (1 = read, 0 = write), bit 62 is the notify request, bits 61:56 are the subsystem ID, bits 55:32 are the register address and bits 31:0 are the write value.
- R2: `fifo_ready` is high only while no instruction is in flight and `soft_rst` is low, so a word is never popped while an earlier instruction or any of its host exchanges is still pending.
- R3: In the cycle after a pop, the instruction is offered downstream; `dn_valid` is low in every cycle where `dn_ready` is low, and the offered fields hold steady until `dn_ready` goes high.
- R4: A write without a notify request completes in the cycle it is accepted (`dn_valid` and `dn_ready` both high): `fifo_ready` is high in the following cycle and no host exchange occurs.
- R5: After a read is accepted, the block waits for `cmp_valid` for any number of cycles; in the cycle after `cmp_valid` is sampled high, `rd_go` is high and `rd_data` equals the `cmp_data` value sampled with it.
- R6: `rd_go` stays high until `rd_rcvd` is sampled high and drops in the next cycle; the next fetch happens only in the cycle after `rd_rcvd` is then sampled low.
- R7: `rd_data` holds steady from the cycle `rd_go` rises until the exchange ends, even if `cmp_valid` pulses again in that window.
- R8: A write with the notify bit set raises `nt_go` in the cycle after its acceptance and runs the same four-phase sequence on `nt_go`/`nt_rcvd`; `rd_go` and `nt_go` are never high together.
- R9: While `soft_rst` is high, the sequencer returns to idle and stays there: `rd_go`, `nt_go`, `dn_valid` and `fifo_ready` are low and `cmp_valid` is ignored; in the cycle after it goes low, `fifo_ready` is high.
- R10: After asynchronous reset, `dn_valid`, `rd_go` and `nt_go` are low and `fifo_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous force-to-idle control |
| fifo_valid | input | 1 | Instruction word available |
| fifo_data | input | 64 | Instruction word |
| fifo_ready | output | 1 | Pops the instruction word |
| dn_valid | output | 1 | Decoded instruction offered downstream |
| dn_ready | input | 1 | Downstream can accept an instruction |
| dn_read | output | 1 | 1 = read, 0 = write |
| dn_subsys | output | 6 | Target subsystem ID |
| dn_addr | output | 24 | Register address |
| dn_wdata | output | 32 | Write value |
| cmp_valid | input | 1 | Read result available |
| cmp_data | input | 32 | Read result |
| rd_go | output | 1 | Read result ready for the host |
| rd_data | output | 32 | Captured read result |
| rd_rcvd | input | 1 | Host has taken the read result |
| nt_go | output | 1 | Commit notification for the host |
| nt_rcvd | input | 1 | Host has seen the notification |

## Verification
The assertions watch every cycle for the parts of the protocol that are local: a go line stays high until its received line is seen and then drops, the returned read value stays steady while its exchange is open, the two go lines never overlap, no pop happens while an exchange is open, an offered instruction stays fixed while `dn_ready` is low, and the soft reset clears all outputs. Only the bench scenarios can show end-to-end facts. These include the correct decoding of each word and its order on the downstream side, the true pacing after a late read completion or a slow host, the exact cycle in which a write frees the fetch, and the return to normal work after a soft reset that interrupts a read.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int SUB_W  = 6;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int WORD_W = 2 + SUB_W + ADDR_W + DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WCMP,
    ST_RHS,
    ST_NHS
  } seq_state_t;

  typedef enum logic [1:0] {
    HS_OFF,
    HS_GO,
    HS_WAIT
  } hs_state_t;
endpackage

// File: rtl/regseq_decode.sv
module regseq_decode #(
  parameter int SUB_W  = 6,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int WORD_W = 2 + SUB_W + ADDR_W + DATA_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_read,
  output logic              want_note,
  output logic [SUB_W-1:0]  subsys,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam int ADDR_LO = DATA_W;
  localparam int SUB_LO  = DATA_W + ADDR_W;

  always_comb begin
    is_read   = word[WORD_W-1];
    want_note = word[WORD_W-2];
    subsys    = word[SUB_LO +: SUB_W];
    addr      = word[ADDR_LO +: ADDR_W];
    wdata     = word[0 +: DATA_W];
  end
endmodule

// File: rtl/regseq_handshake.sv
module regseq_handshake
  import regseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic rcvd,
  output logic go,
  output logic busy,
  output logic done
);
  hs_state_t hs_q, hs_d;

  always_comb begin
    hs_d = hs_q;
    done = 1'b0;
    case (hs_q)
      HS_OFF:  if (start) hs_d = HS_GO;
      HS_GO:   if (rcvd)  hs_d = HS_WAIT;
      HS_WAIT: if (!rcvd) begin
        hs_d = HS_OFF;
        done = 1'b1;
      end
      default: hs_d = HS_OFF;
    endcase
    if (clr) begin
      hs_d = HS_OFF;
      done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= HS_OFF;
    else        hs_q <= hs_d;
  end

  assign go   = (hs_q == HS_GO);
  assign busy = (hs_q != HS_OFF);

  // R6 / R8: go is held until received is seen
  assert_go_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !rcvd && !clr) |=> go);
  // R6 / R8: go drops once received is seen
  assert_go_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rcvd) |=> !go);
  // R6 / R8: completion only after received has returned low
  assert_done_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rcvd && !go));
endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              fifo_valid,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_ready,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_read,
  output logic [SUB_W-1:0]  dn_subsys,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_data,
  output logic              rd_go,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_rcvd,
  output logic              nt_go,
  input  logic              nt_rcvd
);
  localparam int N_CH = 2;   // channel 0: read return, channel 1: notify
  localparam int CH_RD = 0;
  localparam int CH_NT = 1;

  seq_state_t        st_q, st_d;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] rdat_q;
  logic              ld_word, ld_rdat;
  logic              dec_note;
  logic [N_CH-1:0]   hs_start, hs_rcvd, hs_go, hs_busy, hs_done;

  regseq_decode #(
    .SUB_W(SUB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_decode (
    .word(word_q), .is_read(dn_read), .want_note(dec_note),
    .subsys(dn_subsys), .addr(dn_addr), .wdata(dn_wdata)
  );

  assign hs_rcvd[CH_RD] = rd_rcvd;
  assign hs_rcvd[CH_NT] = nt_rcvd;

  for (genvar c = 0; c < N_CH; c++) begin : g_hs
    regseq_handshake u_hs (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .start(hs_start[c]), .rcvd(hs_rcvd[c]),
      .go(hs_go[c]), .busy(hs_busy[c]), .done(hs_done[c])
    );
  end

  assign rd_go = hs_go[CH_RD];
  assign nt_go = hs_go[CH_NT];

  always_comb begin
    st_d     = st_q;
    hs_start = '0;
    ld_word  = 1'b0;
    ld_rdat  = 1'b0;
    case (st_q)
      ST_IDLE:  if (fifo_valid) begin
        ld_word = 1'b1;
        st_d    = ST_ISSUE;
      end
      ST_ISSUE: if (dn_ready) begin
        if (dn_read) begin
          st_d = ST_WCMP;
        end else if (dec_note) begin
          st_d            = ST_NHS;
          hs_start[CH_NT] = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WCMP:  if (cmp_valid) begin
        ld_rdat         = 1'b1;
        hs_start[CH_RD] = 1'b1;
        st_d            = ST_RHS;
      end
      ST_RHS:   if (hs_done[CH_RD]) st_d = ST_IDLE;
      ST_NHS:   if (hs_done[CH_NT]) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (soft_rst) begin
      st_d     = ST_IDLE;
      hs_start = '0;
      ld_word  = 1'b0;
      ld_rdat  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (ld_word) word_q <= fifo_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (ld_rdat) rdat_q <= cmp_data;
  end

  assign fifo_ready = (st_q == ST_IDLE) && !soft_rst;
  assign dn_valid   = (st_q == ST_ISSUE) && dn_ready && !soft_rst;
  assign rd_data    = rdat_q;

  // R2: no pop while any host exchange is open
  assert_no_fetch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (hs_busy == '0));
  // R3: an offered instruction is held while downstream is not ready
  assert_hold_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISSUE && !dn_ready && !soft_rst) |=>
      ($stable({dn_read, dn_subsys, dn_addr, dn_wdata}) && st_q == ST_ISSUE));
  // R7: returned read value steady during its exchange
  assert_rdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_busy[CH_RD] |=> $stable(rd_data));
  // R8: the two go lines never overlap
  assert_one_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_go && nt_go));
  // R9: soft reset clears the handshake outputs
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rd_go && !nt_go && st_q == ST_IDLE));
endmodule

// File: tb/regseq_top_tb_top.sv
module regseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        fifo_valid = 1'b0;
  logic [63:0] fifo_data = '0;
  logic        fifo_ready;
  logic        dn_valid;
  logic        dn_ready = 1'b1;
  logic        dn_read;
  logic [5:0]  dn_subsys;
  logic [23:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_data = '0;
  logic        rd_go;
  logic [31:0] rd_data;
  logic        rd_rcvd = 1'b0;
  logic        nt_go;
  logic        nt_rcvd = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [62:0] exp_q[$];   // {read, subsys, addr, wdata}

  always #10 clk = ~clk;   // 50 MHz

  regseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_read(dn_read),
    .dn_subsys(dn_subsys), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .cmp_valid(cmp_valid), .cmp_data(cmp_data),
    .rd_go(rd_go), .rd_data(rd_data), .rd_rcvd(rd_rcvd),
    .nt_go(nt_go), .nt_rcvd(nt_rcvd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  // monitor: compare every accepted downstream instruction against the scoreboard (R1)
  always @(negedge clk) begin
    if (rst_n && dn_valid) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected instruction", {1'b0, dn_read, dn_subsys, dn_addr, dn_wdata}, 64'h0);
      end else begin
        chk("R1 decoded fields", {1'b0, dn_read, dn_subsys, dn_addr, dn_wdata},
            {1'b0, exp_q.pop_front()});
      end
    end
  end

  // driver: offer one word, return right after the edge that pops it
  task automatic send(input logic rd, input logic nt, input logic [5:0] sub,
                      input logic [23:0] addr, input logic [31:0] dat);
    @(negedge clk);
    fifo_valid = 1'b1;
    fifo_data  = {rd, nt, sub, addr, dat};
    exp_q.push_back({rd, sub, addr, dat});
    while (!fifo_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // write without notify, downstream ready (R3, R4)
  task automatic plain_write(input logic [5:0] sub, input logic [23:0] addr, input logic [31:0] dat);
    send(1'b0, 1'b0, sub, addr, dat);
    @(negedge clk);
    fifo_valid = 1'b0;
    chk("R3 offered after pop", {63'd0, dn_valid}, 64'd1);
    @(negedge clk);
    chk("R4 fetch free after write", {63'd0, fifo_ready}, 64'd1);
    chk("R4 no notify", {63'd0, nt_go}, 64'd0);
  endtask

  // read accepted downstream, completion after `late` cycles
  task automatic issue_read(input logic [23:0] addr, input int late, input logic [31:0] val);
    send(1'b1, 1'b0, 6'h15, addr, 32'h0);
    @(negedge clk);
    fifo_valid = 1'b0;      // accepted at the next edge
    for (int i = 0; i < late; i++) begin
      @(negedge clk);
      chk("R5 no go before completion", {63'd0, rd_go}, 64'd0);
      chk("R2 no fetch while waiting", {63'd0, fifo_ready}, 64'd0);
    end
    cmp_valid = 1'b1;
    cmp_data  = val;
    @(negedge clk);
    cmp_valid = 1'b0;
    cmp_data  = 32'hDEAD_0000;
    chk("R5 go after completion", {63'd0, rd_go}, 64'd1);
    chk("R5 captured value", {32'd0, rd_data}, {32'd0, val});
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 fifo_ready", {63'd0, fifo_ready}, 64'd1);
    chk("R10 dn_valid", {63'd0, dn_valid}, 64'd0);
    chk("R10 rd_go", {63'd0, rd_go}, 64'd0);
    chk("R10 nt_go", {63'd0, nt_go}, 64'd0);

    // back-to-back writes, no notification
    plain_write(6'h01, 24'h000010, 32'h1111_2222);
    plain_write(6'h3F, 24'hFFFFFF, 32'hFFFF_FFFF);
    plain_write(6'h00, 24'h000000, 32'h0000_0000);
    plain_write(6'h2A, 24'h5A5A5A, 32'hA5A5_A5A5);

    // downstream ready held low (R3, R2)
    dn_ready = 1'b0;
    send(1'b0, 1'b0, 6'h07, 24'h123456, 32'hCAFE_F00D);
    @(negedge clk);
    fifo_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R3 valid low while not ready", {63'd0, dn_valid}, 64'd0);
      chk("R3 address held", {40'd0, dn_addr}, {40'd0, 24'h123456});
      chk("R2 no fetch while pending", {63'd0, fifo_ready}, 64'd0);
      @(negedge clk);
    end
    dn_ready = 1'b1;
    #1;
    chk("R3 offered when ready returns", {63'd0, dn_valid}, 64'd1);
    @(negedge clk);
    chk("R4 fetch free after held write", {63'd0, fifo_ready}, 64'd1);

    // late read completion with a slow host (R5, R6, R7)
    issue_read(24'h000ABC, 5, 32'h8765_4321);
    for (int i = 0; i < 3; i++) begin
      if (i == 1) cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      chk("R6 go held until received", {63'd0, rd_go}, 64'd1);
      chk("R7 value steady", {32'd0, rd_data}, {32'd0, 32'h8765_4321});
    end
    rd_rcvd = 1'b1;
    @(negedge clk);
    chk("R6 go drops after received", {63'd0, rd_go}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 no fetch while received high", {63'd0, fifo_ready}, 64'd0);
      chk("R7 value steady after go", {32'd0, rd_data}, {32'd0, 32'h8765_4321});
    end
    rd_rcvd = 1'b0;
    @(negedge clk);
    chk("R6 fetch after received low", {63'd0, fifo_ready}, 64'd1);

    // write with notify, slow host (R8)
    send(1'b0, 1'b1, 6'h22, 24'h0F0F0F, 32'h0BAD_BEEF);
    @(negedge clk);
    fifo_valid = 1'b0;
    @(negedge clk);
    chk("R8 notify go raised", {63'd0, nt_go}, 64'd1);
    chk("R8 read go quiet", {63'd0, rd_go}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 notify go held", {63'd0, nt_go}, 64'd1);
      chk("R8 no fetch during notify", {63'd0, fifo_ready}, 64'd0);
    end
    nt_rcvd = 1'b1;
    @(negedge clk);
    chk("R8 notify go drops", {63'd0, nt_go}, 64'd0);
    wait_neg(2);
    chk("R8 no fetch until received low", {63'd0, fifo_ready}, 64'd0);
    nt_rcvd = 1'b0;
    @(negedge clk);
    chk("R8 fetch after notify", {63'd0, fifo_ready}, 64'd1);

    // soft reset while waiting for a read completion (R9)
    send(1'b1, 1'b0, 6'h05, 24'h000777, 32'h0);
    @(negedge clk);
    fifo_valid = 1'b0;
    @(negedge clk);
    soft_rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (i == 1) begin cmp_valid = 1'b1; cmp_data = 32'h5555_AAAA; end
      @(negedge clk);
      cmp_valid = 1'b0;
      chk("R9 held idle no fetch", {63'd0, fifo_ready}, 64'd0);
      chk("R9 completion ignored", {63'd0, rd_go}, 64'd0);
      chk("R9 no downstream offer", {63'd0, dn_valid}, 64'd0);
    end
    soft_rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after release", {63'd0, fifo_ready}, 64'd1);
    chk("R9 read go stays low", {63'd0, rd_go}, 64'd0);

    // soft reset during an open read-return exchange (R9)
    issue_read(24'h000999, 1, 32'h0102_0304);
    soft_rst = 1'b1;
    @(negedge clk);
    chk("R9 go cleared", {63'd0, rd_go}, 64'd0);
    soft_rst = 1'b0;
    @(negedge clk);
    chk("R9 ready after exchange cut", {63'd0, fifo_ready}, 64'd1);

    // normal operation resumes
    plain_write(6'h11, 24'h000001, 32'h7777_7777);
    wait_neg(2);
    chk("R1 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule